// File: doc/BRIEF.md
# Interprocessor Mailbox

This block lets several processors pass 32-bit words to one another through a shared, memory-mapped peripheral. It contains six independent message queues. Each queue has a data port that pushes a word on a write and pops the oldest word on a read. Each queue also has a full flag and a word count that software can read.

Four users, such as a host processor and its accelerators, each own an interrupt status register and an interrupt enable register. Every queue can raise two events:

- a new-message event when a word is accepted into the queue;
- a not-full event when a pop frees a slot in a queue that was full.

Every event is posted to every user's status register. Each user then picks the events it cares about through its own enable register, and acknowledges an event by writing a one to the status bit.

The block is reached through a plain single-cycle register port. An access is accepted in the cycle that `bus_req` is high. Read data appears combinationally in that same cycle, and the pop takes effect at the clock edge that ends the access. The port has no back-pressure: every access completes in one cycle, and no stall or wait state exists. A configuration register, a fixed revision register and a system status register complete the map.

Top module: `mbx_top`

## Requirements
- R1: Writing the data port of queue m (byte offset 0x40 + 4*m, m = 0..5) appends the word. Reading it returns and removes the oldest word, so words come out in first-in first-out order. Each queue holds 4 words.
- R2: A write to a full queue is discarded and leaves the count and the contents unchanged. A read of an empty queue returns zero and changes nothing.
- R3: The full-flag register of queue m (offset 0x80 + 4*m) reads 1 while that queue holds 4 words and 0 otherwise.
- R4: The count register of queue m (offset 0xC0 + 4*m) reads the number of words currently queued, and 0 when the queue is empty.
- R5: An accepted write to queue m sets bit 2*m of every user's status register. A pop that takes queue m from full to not full sets bit 2*m+1 of every user's status register. A discarded write sets nothing.
- R6: User u's status register is at offset 0x100 + 8*u. Writing it clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R7: User u's enable register is at offset 0x104 + 8*u, and its low 12 bits read back as written. Output `irq_o[u]` is high exactly when some bit is set in both that user's status register and its enable register.
- R8: The configuration register at 0x10 keeps bits 0 and 4 of a write and reads the other bits as zero. The revision register at 0x00 reads 0x00000021. The system status register at 0x14 reads 1. Any other address reads zero.
- R9: Reset empties every queue and clears all status, enable and configuration registers, so that every `irq_o` bit is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_req | input | 1 | Access strobe, one access per cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 9 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the read |
| irq_o | output | 4 | Interrupt line per user |

## Verification
The bench fills a queue to capacity and pushes one extra word. A design that overran the queue would show a count of 5, or would hand back the dropped word later. It then drains the queue past empty. A design that moved its pointers on an empty pop would return stale data or a count that wraps. It also checks that only the pop from full raises the not-full event, and that writing zeros to a status register keeps pending events. Finally, it checks that the enable register alone gates `irq_o`, and that status is shared by all users while enables stay per user. A design that mixed up the users or the event pairing would raise the wrong interrupt line.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  // byte offsets of the register groups
  localparam int OFS_REV      = 'h000;
  localparam int OFS_CFG      = 'h010;
  localparam int OFS_SYS      = 'h014;
  localparam int OFS_MSG      = 'h040;
  localparam int OFS_FULL     = 'h080;
  localparam int OFS_CNT      = 'h0C0;
  localparam int OFS_USR      = 'h100;
  localparam int USR_STRIDE   = 8;
  localparam int BOX_STRIDE   = 4;

  localparam logic [31:0] REV_VALUE = 32'h0000_0021;
  localparam logic [31:0] CFG_MASK  = 32'h0000_0011;
  localparam logic [31:0] SYS_READY = 32'h0000_0001;
endpackage

// File: rtl/mbx_fifo.sv
module mbx_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 4,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          pushed,
  output logic          freed
);
  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] rd_ptr, wr_ptr;
  logic          empty, do_push, do_pop;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign pushed  = do_push;
  assign freed   = do_pop && full;
  assign rdata   = empty ? '0 : mem[rd_ptr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= nxt(wr_ptr);
      if (do_pop)  rd_ptr <= nxt(rd_ptr);
      count <= count + CW'(do_push) - CW'(do_pop);
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= wdata;
  end

  // R2: a write into a full queue leaves the count where it was
  p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop) |=> $stable(count));
  // R2: popping an empty queue does not wrap the count
  p_no_underflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && pop && !push) |=> (count == '0));
  // R4: count never exceeds the depth
  p_count_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
endmodule

// File: rtl/mbx_user_irq.sv
module mbx_user_irq #(
  parameter int EW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [EW-1:0] evt,
  input  logic          clr_we,
  input  logic          en_we,
  input  logic [EW-1:0] wdata,
  output logic [EW-1:0] status,
  output logic [EW-1:0] enable,
  output logic          irq
);
  logic [EW-1:0] clr_mask;

  assign clr_mask = clr_we ? wdata : '0;
  assign irq      = |(status & enable);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status <= '0;
      enable <= '0;
    end else begin
      // hardware events are applied after the clear so they win
      status <= (status & ~clr_mask) | evt;
      if (en_we) enable <= wdata;
    end
  end

  // R5: every posted event shows in status on the next cycle
  p_event_lands_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (evt != '0) |=> ((status & $past(evt)) == $past(evt)));
  // R6: bits written as one are cleared when no event competes
  p_w1c_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && evt == '0) |=> ((status & $past(wdata)) == '0));
  // R6: bits written as zero are kept
  p_w0_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we) |=> ((status & ~$past(wdata)) == ($past(status) & ~$past(wdata))));
  // R7: with nothing enabled the line stays low
  p_irq_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (enable == '0) |-> !irq);
endmodule

// File: rtl/mbx_top.sv
module mbx_top #(
  parameter int NB    = 6,
  parameter int NU    = 4,
  parameter int DEPTH = 4,
  parameter int DW    = 32,
  parameter int AW    = 9,
  localparam int EW   = 2 * NB,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_req,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic [NU-1:0] irq_o
);
  import mbx_pkg::*;

  logic          wr_acc, rd_acc;
  logic [DW-1:0] q_rdata [NB];
  logic [CW-1:0] q_count [NB];
  logic [NB-1:0] q_full, q_pushed, q_freed, sel_msg;
  logic [EW-1:0] evt;
  logic [EW-1:0] u_status [NU];
  logic [EW-1:0] u_enable [NU];
  logic [NU-1:0] sel_st, sel_en;
  logic [DW-1:0] cfg_q;

  assign wr_acc = bus_req && bus_we;
  assign rd_acc = bus_req && !bus_we;

  for (genvar m = 0; m < NB; m++) begin : g_box
    assign sel_msg[m] = (bus_addr == AW'(OFS_MSG + BOX_STRIDE * m));

    mbx_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
      .clk    (clk),
      .rst_n  (rst_n),
      .push   (wr_acc && sel_msg[m]),
      .pop    (rd_acc && sel_msg[m]),
      .wdata  (bus_wdata),
      .rdata  (q_rdata[m]),
      .count  (q_count[m]),
      .full   (q_full[m]),
      .pushed (q_pushed[m]),
      .freed  (q_freed[m])
    );

    // interleaved event pair: even bit new word, odd bit slot freed
    assign evt[2*m]   = q_pushed[m];
    assign evt[2*m+1] = q_freed[m];
  end

  for (genvar u = 0; u < NU; u++) begin : g_user
    assign sel_st[u] = (bus_addr == AW'(OFS_USR + USR_STRIDE * u));
    assign sel_en[u] = (bus_addr == AW'(OFS_USR + USR_STRIDE * u + 4));

    mbx_user_irq #(.EW(EW)) u_irq (
      .clk    (clk),
      .rst_n  (rst_n),
      .evt    (evt),
      .clr_we (wr_acc && sel_st[u]),
      .en_we  (wr_acc && sel_en[u]),
      .wdata  (bus_wdata[EW-1:0]),
      .status (u_status[u]),
      .enable (u_enable[u]),
      .irq    (irq_o[u])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else if (wr_acc && bus_addr == AW'(OFS_CFG)) cfg_q <= bus_wdata & CFG_MASK;
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == AW'(OFS_REV)) bus_rdata = REV_VALUE;
    if (bus_addr == AW'(OFS_CFG)) bus_rdata = cfg_q;
    if (bus_addr == AW'(OFS_SYS)) bus_rdata = SYS_READY;
    for (int m = 0; m < NB; m++) begin
      if (sel_msg[m]) bus_rdata = q_rdata[m];
      if (bus_addr == AW'(OFS_FULL + BOX_STRIDE * m)) bus_rdata = DW'(q_full[m]);
      if (bus_addr == AW'(OFS_CNT + BOX_STRIDE * m))  bus_rdata = DW'(q_count[m]);
    end
    for (int u = 0; u < NU; u++) begin
      if (sel_st[u]) bus_rdata = DW'(u_status[u]);
      if (sel_en[u]) bus_rdata = DW'(u_enable[u]);
    end
  end

  // R8: configuration never holds bits outside the two idle enables
  p_cfg_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q & ~CFG_MASK) == '0);
  // R5: all users see the same event, so a new word reaches user 0 and the last user alike
  p_fanout_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (q_pushed != '0) |=> ((u_status[0] & u_status[NU-1] & $past(evt)) == $past(evt)));
endmodule

// File: tb/tb_mbx_top.sv
`timescale 1ns/1ps
module tb_mbx_top;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        bus_req = 0, bus_we = 0;
  logic [8:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [3:0]  irq_o;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  mbx_top dut (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  // entry = {read, req number, byte address, write data or expected read}
  localparam int NV = 34;
  localparam logic [45:0] VEC [NV] = '{
    {1'b1, 4'd8, 9'h000, 32'h21},  // R8 revision
    {1'b0, 4'd1, 9'h040, 32'hA1},  // R1 pushes into queue 0
    {1'b0, 4'd1, 9'h040, 32'hA2},
    {1'b1, 4'd4, 9'h0C0, 32'h2},   // R4 count
    {1'b1, 4'd3, 9'h080, 32'h0},   // R3 not full
    {1'b0, 4'd1, 9'h040, 32'hA3},
    {1'b0, 4'd1, 9'h040, 32'hA4},
    {1'b1, 4'd3, 9'h080, 32'h1},   // R3 full
    {1'b0, 4'd2, 9'h040, 32'hA5},  // R2 dropped
    {1'b1, 4'd2, 9'h0C0, 32'h4},
    {1'b1, 4'd1, 9'h040, 32'hA1},  // pop from full
    {1'b1, 4'd3, 9'h080, 32'h0},
    {1'b1, 4'd5, 9'h100, 32'h3},   // R5 both events of queue 0
    {1'b1, 4'd5, 9'h118, 32'h3},   // R5 last user too
    {1'b1, 4'd1, 9'h040, 32'hA2},
    {1'b1, 4'd1, 9'h040, 32'hA3},
    {1'b1, 4'd1, 9'h040, 32'hA4},
    {1'b1, 4'd2, 9'h040, 32'h0},   // R2 empty read
    {1'b1, 4'd2, 9'h0C0, 32'h0},
    {1'b0, 4'd1, 9'h054, 32'h55},  // queue 5
    {1'b1, 4'd5, 9'h100, 32'h403},
    {1'b0, 4'd6, 9'h100, 32'h1},   // R6 clear bit 0
    {1'b1, 4'd6, 9'h100, 32'h402},
    {1'b0, 4'd6, 9'h100, 32'h0},   // R6 zeros keep
    {1'b1, 4'd6, 9'h100, 32'h402},
    {1'b1, 4'd6, 9'h108, 32'h403}, // other user untouched
    {1'b0, 4'd8, 9'h010, 32'hFFFF_FFFF},
    {1'b1, 4'd8, 9'h010, 32'h11},  // R8 config mask
    {1'b1, 4'd8, 9'h014, 32'h1},
    {1'b1, 4'd4, 9'h0D4, 32'h1},
    {1'b1, 4'd1, 9'h054, 32'h55},
    {1'b1, 4'd4, 9'h0D4, 32'h0},
    {1'b1, 4'd7, 9'h104, 32'h0},   // R7 enable after reset
    {1'b1, 4'd5, 9'h100, 32'h402}  // pop from non-full: no event
  };

  task automatic acc(input bit rd, input logic [8:0] a, input logic [31:0] d,
                     output logic [31:0] r);
    @(negedge clk);
    bus_req = 1; bus_we = !rd; bus_addr = a; bus_wdata = d;
    #1 r = bus_rdata;
    @(posedge clk);
    #1 bus_req = 0; bus_we = 0;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic rd_chk(input string tag, input logic [8:0] a, input logic [31:0] exp);
    logic [31:0] r;
    acc(1, a, '0, r);
    chk(tag, r, exp);
  endtask

  task automatic wr(input logic [8:0] a, input logic [31:0] d);
    logic [31:0] r;
    acc(0, a, d, r);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk("R9 irq after reset", {28'h0, irq_o}, 32'h0);
    rd_chk("R9 count after reset", 9'h0C0, 32'h0);

    for (int i = 0; i < NV; i++) begin
      logic [31:0] r;
      acc(VEC[i][45], VEC[i][40:32], VEC[i][31:0], r);
      if (VEC[i][45]) chk($sformatf("R%0d table entry %0d", VEC[i][44:41], i), r, VEC[i][31:0]);
    end

    // R7: interrupt gating by the per-user enable
    @(negedge clk);
    chk("R7 no line without enables", {28'h0, irq_o}, 32'h0);
    wr(9'h114, 32'h4);                 // user 2 watches queue 1 new word
    @(negedge clk);
    chk("R7 enable alone raises nothing", {28'h0, irq_o}, 32'h0);
    wr(9'h044, 32'hBEEF);              // R5 push into queue 1
    @(negedge clk);
    chk("R7 user 2 line on new word", {28'h0, irq_o}, 32'h4);
    wr(9'h110, 32'h4);                 // R6 acknowledge
    @(negedge clk);
    chk("R6 acknowledge drops line", {28'h0, irq_o}, 32'h0);
    wr(9'h114, 32'h404);               // bit 10 still pending for user 2
    @(negedge clk);
    chk("R7 pending bit raises line", {28'h0, irq_o}, 32'h4);
    wr(9'h114, 32'h4);
    @(negedge clk);
    chk("R7 disable drops line", {28'h0, irq_o}, 32'h0);
    rd_chk("R7 enable readback", 9'h114, 32'h4);
    rd_chk("R5 user 0 saw queue 1 word", 9'h100, 32'h406);

    // R9: reset in mid run
    wr(9'h10C, 32'hFFF);
    @(negedge clk);
    chk("R7 user 1 line up", {28'h0, irq_o}, 32'h2);
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R9 lines low", {28'h0, irq_o}, 32'h0);
    rd_chk("R9 queue 1 empty", 9'h0C4, 32'h0);
    rd_chk("R9 status clear", 9'h108, 32'h0);
    rd_chk("R9 enable clear", 9'h10C, 32'h0);
    rd_chk("R9 config clear", 9'h010, 32'h0);
    rd_chk("R8 unmapped reads zero", 9'h1F0, 32'h0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule